// File: doc/BRIEF.md
# Descriptor-Driven DMA Engine

This block is a single-channel DMA engine. The host does not program transfer registers. It places a three-word command block in memory and writes only the block's address into the engine. The engine then reads the block over the memory bus, one word at a time. The first word is the source pointer, the second the destination pointer, and the third the byte count.

Data then moves one word at a time. Each word is paced by a request/acknowledge handshake with a device controller. When the device raises its request, the engine reads the word at the source pointer and writes it to the destination pointer. It asserts acknowledge from the start of the write and holds it until the device drops its request. Either pointer can name a device data register, so one engine serves both directions. Every memory access waits for a bus grant, which models arbitration against the CPU. Completion raises a sticky done flag and a one-cycle interrupt pulse.

Top module: `dma_desc_engine`

## Requirements
- R1: While `rst_ni` is low, and after its release until a command is accepted, `busy_o`, `done_o`, `irq_o`, `mem_req_o` and `dack_o` are all low.
- R2: A command write (`cmd_we_i` high) in the idle state is accepted. The engine then issues three reads, in order, at addresses P, P+4 and P+8, where P is `cmd_addr_i`. It loads them as source pointer, destination pointer and byte count. The two low bits of the byte count are ignored (treated as zero).
- R3: Every memory access keeps `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stable until a cycle in which `mem_gnt_i` is high. The access completes in that cycle, and read data is taken from `mem_rdata_i` in that same cycle.
- R4: No data access starts until `dreq_i` is high. Each word is a read (`mem_we_o` low) at the source pointer, followed by a write (`mem_we_o` high) at the destination pointer carrying the data just read.
- R5: `dack_o` is high from the first cycle of a word's write until the cycle after `dreq_i` is sampled low. It is never released while `dreq_i` is still high.
- R6: After each completed write, the source and destination pointers each advance by 4 and the remaining count drops by 4. The transfer ends when the count reaches zero.
- R7: A byte count of zero (after masking) completes the transfer without any data access and without asserting `dack_o`.
- R8: At completion, `done_o` rises and stays high until the next accepted command. `irq_o` pulses high for exactly one cycle, in the same cycle that `done_o` rises.
- R9: A command write while `busy_o` is high is ignored. The running transfer continues unchanged, and the ignored block is never read or acted on.
- R10: `busy_o` is high from the cycle after a command is accepted until the cycle in which `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Host strobe: start a transfer from the command block at `cmd_addr_i` |
| cmd_addr_i | input | AW | Memory address of the command block |
| busy_o | output | 1 | Engine is fetching or transferring |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | One-cycle completion interrupt |
| mem_req_o | output | 1 | Memory access request |
| mem_gnt_i | input | 1 | Bus grant; the access completes in a granted cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid in the granted cycle |
| dreq_i | input | 1 | Device request: a word is ready |
| dack_o | output | 1 | Acknowledge to the device |

## Verification
The bench uses a grant that is withheld for random stretches. A design that moved its address before the grant, or sampled read data in the wrong cycle, would put the wrong word at the wrong address.

Some devices hold their request several cycles after acknowledge. A design that dropped acknowledge early, or that serviced the same request twice, would duplicate words and miscompare on `dack_o`.

The bench also covers a zero count, which must finish with no acknowledge at all, and a count with its low bits set, which must stop one word short. A command written mid-transfer must leave the ignored destination untouched and must not break the running copy.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_READ,
    ST_WRITE,
    ST_HOLD
  } dma_state_e;

  // command block: source, destination, byte count
  localparam int unsigned DESC_WORDS = 3;
endpackage

// File: rtl/dma_desc_fsm.sv
module dma_desc_fsm
  import dma_desc_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic             dreq_i,
  input  logic             gnt_i,
  input  logic             cnt_zero_i,
  output dma_state_e       state_o,
  output logic [IDX_W-1:0] fidx_o,
  output logic             dack_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             irq_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  dma_state_e state_q, state_d;
  logic [IDX_W-1:0] fidx_q;
  logic done_q, irq_q;
  logic accept, complete;

  assign accept   = (state_q == ST_IDLE) && cmd_we_i;
  assign complete = (state_q == ST_WAIT) && cnt_zero_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_we_i) state_d = ST_FETCH;
      ST_FETCH: if (gnt_i && fidx_q == LAST_IDX) state_d = ST_WAIT;
      ST_WAIT: begin
        if (cnt_zero_i)  state_d = ST_IDLE;
        else if (dreq_i) state_d = ST_READ;
      end
      ST_READ:  if (gnt_i) state_d = ST_WRITE;
      ST_WRITE: if (gnt_i) state_d = ST_HOLD;
      ST_HOLD:  if (!dreq_i) state_d = ST_WAIT;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fidx_q  <= '0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= complete;
      if (accept) begin
        done_q <= 1'b0;
        fidx_q <= '0;
      end else begin
        if (complete) done_q <= 1'b1;
        if (state_q == ST_FETCH && gnt_i && fidx_q != LAST_IDX)
          fidx_q <= fidx_q + 1'b1;
      end
    end
  end

  assign state_o = state_q;
  assign fidx_o  = fidx_q;
  assign dack_o  = (state_q == ST_WRITE) || (state_q == ST_HOLD);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign irq_o   = irq_q;

  // R5
  dack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o && dreq_i |=> dack_o);
  // R8
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R8
  irq_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o && !busy_o);
  // R4
  no_early_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_WAIT && !dreq_i |=> state_o != ST_READ);
endmodule

// File: rtl/dma_desc_regs.sv
module dma_desc_regs
  import dma_desc_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  dma_state_e       state_i,
  input  logic [IDX_W-1:0] fidx_i,
  input  logic             gnt_i,
  input  logic             accept_i,
  input  logic [AW-1:0]    cmd_addr_i,
  input  logic [DW-1:0]    rdata_i,
  output logic [AW-1:0]    ptr_o,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic             cnt_zero_o,
  output logic [DW-1:0]    buf_o
);
  localparam int unsigned STEP = DW / 8;
  localparam logic [DW-1:0] CNT_MASK = ~DW'(STEP - 1);

  logic [AW-1:0] ptr_q, src_q, dst_q;
  logic [DW-1:0] cnt_q, buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      buf_q <= '0;
    end else begin
      if (accept_i) ptr_q <= cmd_addr_i;
      unique case (state_i)
        ST_FETCH: if (gnt_i) begin
          // order of the command block words is fixed
          unique case (fidx_i)
            IDX_W'(0): src_q <= AW'(rdata_i);
            IDX_W'(1): dst_q <= AW'(rdata_i);
            default:   cnt_q <= rdata_i & CNT_MASK;
          endcase
        end
        ST_READ: if (gnt_i) buf_q <= rdata_i;
        ST_WRITE: if (gnt_i) begin
          src_q <= src_q + AW'(STEP);
          dst_q <= dst_q + AW'(STEP);
          cnt_q <= cnt_q - DW'(STEP);
        end
        default: ;
      endcase
    end
  end

  assign ptr_o      = ptr_q;
  assign src_o      = src_q;
  assign dst_o      = dst_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign buf_o      = buf_q;

  // R6
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_WRITE && gnt_i |=>
      (src_o - $past(src_o)) == AW'(STEP) && (dst_o - $past(dst_o)) == AW'(STEP));
endmodule

// File: rtl/dma_desc_bus.sv
module dma_desc_bus
  import dma_desc_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnt_i,
  input  dma_state_e       state_i,
  input  logic [IDX_W-1:0] fidx_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [DW-1:0]    buf_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o
);
  localparam int unsigned OFF_SH = $clog2(DW / 8);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr_i + (AW'(fidx_i) << OFF_SH);
      end
      ST_READ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src_i;
      end
      ST_WRITE: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = dst_i;
        mem_wdata_o = buf_i;
      end
      default: ;
    endcase
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !gnt_i |=>
      mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dma_desc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [AW-1:0] cmd_addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          irq_o,
  output logic          mem_req_o,
  input  logic          mem_gnt_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          dreq_i,
  output logic          dack_o
);
  localparam int unsigned IDX_W = $clog2(DESC_WORDS);

  dma_state_e       state;
  logic [IDX_W-1:0] fidx;
  logic [AW-1:0]    desc_ptr, src, dst;
  logic [DW-1:0]    wbuf;
  logic             cnt_zero, accept;

  assign accept = (state == ST_IDLE) && cmd_we_i;

  dma_desc_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (cmd_we_i),
    .dreq_i    (dreq_i),
    .gnt_i     (mem_gnt_i),
    .cnt_zero_i(cnt_zero),
    .state_o   (state),
    .fidx_o    (fidx),
    .dack_o    (dack_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .irq_o     (irq_o)
  );

  dma_desc_regs #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .fidx_i    (fidx),
    .gnt_i     (mem_gnt_i),
    .accept_i  (accept),
    .cmd_addr_i(cmd_addr_i),
    .rdata_i   (mem_rdata_i),
    .ptr_o     (desc_ptr),
    .src_o     (src),
    .dst_o     (dst),
    .cnt_zero_o(cnt_zero),
    .buf_o     (wbuf)
  );

  dma_desc_bus #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gnt_i      (mem_gnt_i),
    .state_i    (state),
    .fidx_i     (fidx),
    .ptr_i      (desc_ptr),
    .src_i      (src),
    .dst_i      (dst),
    .buf_i      (wbuf),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  // R9
  busy_cmd_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cmd_we_i |=> $stable(desc_ptr));
  // R5
  write_under_dack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> dack_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !dack_o);
endmodule

// File: tb/sim_dma_desc_engine.sv
`timescale 1ns/1ps
module sim_dma_desc_engine;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we_i = 1'b0;
  logic [31:0] cmd_addr_i = '0;
  logic        mem_gnt_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        dreq_i = 1'b0;
  logic        busy_o, done_o, irq_o, mem_req_o, mem_we_o, dack_o;
  logic [31:0] mem_addr_o, mem_wdata_o;

  always #4 clk = ~clk;

  dma_desc_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_we_i(cmd_we_i), .cmd_addr_i(cmd_addr_i),
    .busy_o(busy_o), .done_o(done_o), .irq_o(irq_o),
    .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .dreq_i(dreq_i), .dack_o(dack_o)
  );

  logic [31:0] mem [0:255];
  // reference model: 0 idle,1 fetch,2 wait,3 read,4 write,5 hold
  int          ph = 0, fi = 0;
  logic [31:0] m_ptr = '0, m_src = '0, m_dst = '0, m_cnt = '0, m_buf = '0;
  bit          m_done = 0, m_irq = 0;
  logic        s_req = 0, s_we = 0;
  logic [31:0] s_addr = '0, s_wdata = '0;
  bit          pend_cmd = 0;
  logic [31:0] pend_addr = '0;
  int          gnt_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          dev_on = 0;
  int          dev_gap = 0, dev_hold = 0, gap_cnt = 0, hold_cnt = 0;
  int          dack_seen = 0, irq_seen = 0, cyc = 0;
  int          vecs = 0, errs = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_step();
    logic [31:0] rd;
    rd = mem_rdata_i;
    m_irq = 0;
    if (!rst_ni) begin
      ph = 0; fi = 0; m_done = 0;
      return;
    end
    case (ph)
      0: if (cmd_we_i) begin m_ptr = cmd_addr_i; fi = 0; ph = 1; m_done = 0; end
      1: if (mem_gnt_i) begin
        if (fi == 0) m_src = rd;
        else if (fi == 1) m_dst = rd;
        else m_cnt = rd & 32'hFFFF_FFFC;
        if (fi == 2) ph = 2; else fi++;
      end
      2: if (m_cnt == 0) begin ph = 0; m_done = 1; m_irq = 1; end
         else if (dreq_i) ph = 3;
      3: if (mem_gnt_i) begin m_buf = rd; ph = 4; end
      4: if (mem_gnt_i) begin m_src += 4; m_dst += 4; m_cnt -= 4; ph = 5; end
      5: if (!dreq_i) ph = 2;
      default: ph = 0;
    endcase
  endtask

  task automatic compare();
    bit exp_req;
    exp_req = (ph == 1) || (ph == 3) || (ph == 4);
    chk("R10 busy_o", busy_o, ph != 0);
    chk("R3 mem_req_o", mem_req_o, exp_req);
    chk("R8 done_o", done_o, m_done);
    chk("R8 irq_o", irq_o, m_irq);
    chk("R5 dack_o", dack_o, (ph == 4) || (ph == 5));
    if (exp_req) begin
      chk("R4 mem_we_o", mem_we_o, ph == 4);
      case (ph)
        1: chk("R2 fetch address", mem_addr_o, m_ptr + 32'(4 * fi));
        3: chk("R4 source address", mem_addr_o, m_src);
        default: begin
          chk("R6 destination address", mem_addr_o, m_dst);
          chk("R4 write data", mem_wdata_o, m_buf);
        end
      endcase
    end
  endtask

  task automatic drive();
    cmd_we_i   = pend_cmd;
    cmd_addr_i = pend_cmd ? pend_addr : 32'h0;
    pend_cmd   = 0;
    if (gnt_mode == 0) mem_gnt_i = 1'b1;
    else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_gnt_i = lfsr[0];
    end
    if (!dev_on) dreq_i = 1'b0;
    else if (!dreq_i) begin
      if (gap_cnt <= 0) begin dreq_i = 1'b1; hold_cnt = dev_hold; end
      else gap_cnt--;
    end else if (dack_o) begin
      if (hold_cnt <= 0) begin dreq_i = 1'b0; gap_cnt = dev_gap; end
      else hold_cnt--;
    end
    mem_rdata_i = mem[mem_addr_o[9:2]];
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    if (rst_ni && s_req && s_we && mem_gnt_i) mem[s_addr[9:2]] = s_wdata;
    model_step();
    @(negedge clk);
    compare();
    s_req = mem_req_o; s_we = mem_we_o; s_addr = mem_addr_o; s_wdata = mem_wdata_o;
    if (dack_o) dack_seen++;
    if (irq_o) irq_seen++;
    drive();
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  task automatic put_desc(int unsigned base, int unsigned src, int unsigned dst, int unsigned cnt);
    mem[base >> 2]       = src;
    mem[(base >> 2) + 1] = dst;
    mem[(base >> 2) + 2] = cnt;
  endtask

  task automatic launch(logic [31:0] p);
    pend_cmd = 1; pend_addr = p;
    tick();
  endtask

  task automatic wait_done(string tag, int limit);
    int n;
    n = 0;
    tick();
    while ((busy_o || !done_o) && n < limit) begin tick(); n++; end
    chk(tag, n < limit, 1);
  endtask

  task automatic check_copy(string tag, int unsigned src, int unsigned dst, int nwords);
    for (int i = 0; i < nwords; i++)
      chk(tag, mem[(dst >> 2) + i], mem[(src >> 2) + i]);
    chk({tag, " end untouched"}, mem[(dst >> 2) + nwords], 32'hEEEE_0000 | ((dst >> 2) + nwords));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hEEEE_0000 | i;
    for (int i = 64; i < 128; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);

    // R1 reset state
    for (int i = 0; i < 3; i++) tick();
    chk("R1 busy_o in reset", busy_o, 0);
    chk("R1 done_o in reset", done_o, 0);
    chk("R1 irq_o in reset", irq_o, 0);
    chk("R1 mem_req_o in reset", mem_req_o, 0);
    chk("R1 dack_o in reset", dack_o, 0);
    rst_ni = 1'b1;
    dev_on = 1;
    for (int i = 0; i < 3; i++) tick();
    chk("R1 idle after reset", {busy_o, done_o, mem_req_o, dack_o}, 0);

    // four words, grant always, fast device
    put_desc(32'h000, 32'h100, 32'h200, 16);
    launch(32'h000);
    wait_done("R6 four-word run completes", 500);
    check_copy("R6 four-word copy", 32'h100, 32'h200, 4);

    // three words, random grant, slow device, ignored mid-run command (R9)
    gnt_mode = 1; dev_gap = 3; dev_hold = 2;
    put_desc(32'h010, 32'h140, 32'h240, 12);
    put_desc(32'h020, 32'h160, 32'h300, 8);
    launch(32'h010);
    tick(); tick();
    launch(32'h020);
    wait_done("R3 random-grant run completes", 2000);
    check_copy("R4 random-grant copy", 32'h140, 32'h240, 3);
    chk("R9 ignored block dst word0", mem[32'h300 >> 2], 32'hEEEE_0000 | (32'h300 >> 2));
    chk("R9 ignored block dst word1", mem[(32'h300 >> 2) + 1], 32'hEEEE_0000 | ((32'h300 >> 2) + 1));

    // zero count
    dack_seen = 0;
    put_desc(32'h030, 32'h100, 32'h340, 0);
    launch(32'h030);
    wait_done("R7 zero-count run completes", 500);
    chk("R7 no acknowledge on zero count", dack_seen, 0);
    chk("R7 no write on zero count", mem[32'h340 >> 2], 32'hEEEE_0000 | (32'h340 >> 2));

    // count 10: low bits ignored, two words
    gnt_mode = 0; dev_gap = 0; dev_hold = 1;
    put_desc(32'h040, 32'h180, 32'h380, 10);
    launch(32'h040);
    wait_done("R2 masked-count run completes", 500);
    check_copy("R2 masked count copies two words", 32'h180, 32'h380, 2);

    // single word
    gnt_mode = 1; dev_gap = 1; dev_hold = 0;
    put_desc(32'h050, 32'h1C0, 32'h3C0, 4);
    launch(32'h050);
    wait_done("R6 single-word run completes", 500);
    check_copy("R6 single-word copy", 32'h1C0, 32'h3C0, 1);

    for (int i = 0; i < 4; i++) tick();
    chk("R8 done_o stays high", done_o, 1);
    chk("R8 one irq per accepted command", irq_seen, 5);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule